// File: doc/BRIEF.md
# Fully Associative Read Cache with First-In-First-Out Replacement

This block is a small read-only cache placed between a processor-side request port and a slower main-memory port. Words are addressed with a 12-bit address and carry 16 bits of data. Every cache line holds one complete address, one data word and a valid flag. There is no index field: the whole request address acts as the tag, and it is compared against every line in parallel.

A request that matches a valid line returns the stored word one clock edge after it is accepted, and main memory is not touched. A request that matches no line is forwarded to main memory over a request/acknowledge handshake with variable latency. The returned word is passed to the processor and installed together with its address. Empty lines are used first. Once every line is valid, a rotating pointer picks the line that was filled earliest. Writes, coherence and multi-word blocks are not handled.

Top module: `assoc_fifo_cache`

## Requirements
- R1: After reset, req_ready is 1, resp_valid is 0 and mem_req is 0. Every line is invalid, so the first lookup of any address is a miss.
- R2: A request accepted while its address matches a valid line sets resp_valid=1 and resp_hit=1 in the cycle after the accepting edge, with resp_data equal to the stored word. mem_req stays 0.
- R3: A miss is accepted at one edge. From the next edge, mem_req is 1, mem_addr holds the requested address unchanged, and req_ready is 0 until mem_ack is sampled high.
- R4: At the edge where mem_ack is sampled high during a miss, the block registers resp_valid=1, resp_hit=0 and resp_data equal to mem_data. It also drops mem_req and raises req_ready.
- R5: A completed miss installs its address and data, so a later request for the same address hits and returns that word.
- R6: While any line is invalid, a miss fills the lowest-numbered invalid line, and no valid line is replaced. The number of valid lines never decreases.
- R7: When all lines are valid, a miss replaces the line whose current contents were installed earliest (first-in-first-out).
- R8: The replacement pointer advances by one, wrapping, only when a valid line is replaced. Hits and fills of invalid lines leave it unchanged.
- R9: All 12 address bits take part in the match. Addresses that differ only in their upper bits are distinct lines.
- R10: A req_valid pulse while req_ready is 0 is ignored. It produces no response and installs nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Processor read request strobe |
| req_addr | input | ADDR_W | Requested word address |
| req_ready | output | 1 | High when a request can be accepted |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_hit | output | 1 | Response came from the cache (1) or memory (0) |
| resp_data | output | DATA_W | Returned data word |
| mem_req | output | 1 | Main-memory read request, held until acknowledged |
| mem_addr | output | ADDR_W | Main-memory read address |
| mem_ack | input | 1 | Main memory has placed the word on mem_data |
| mem_data | input | DATA_W | Word returned by main memory |

## Verification
A hit response is due in the cycle right after the edge that accepts the request. A miss response is due in the cycle right after the edge that samples mem_ack. The bench keeps a free-running cycle count. Each expected item carries the cycle in which its response must appear: the driver writes it for a hit, and the memory model records the acknowledge cycle for a miss. The monitor compares the arrival cycle as well as the hit flag and the data. A response that arrives early, late or with no pending item is reported.

// File: rtl/assoc_cache_pkg.sv
package assoc_cache_pkg;

  typedef enum logic {
    ST_LOOKUP = 1'b0,
    ST_FILL   = 1'b1
  } cache_state_e;

endpackage

// File: rtl/assoc_cache_match.sv
module assoc_cache_match #(
  parameter int ADDR_W  = 12,
  parameter int ENTRIES = 4
) (
  input  logic [ADDR_W-1:0]              lookup_addr,
  input  logic [ENTRIES-1:0][ADDR_W-1:0] tag_vec,
  input  logic [ENTRIES-1:0]             valid_vec,
  output logic                           hit,
  output logic [((ENTRIES > 1) ? $clog2(ENTRIES) : 1)-1:0] hit_idx
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] match_vec;

  // one comparator per line, all evaluated in parallel
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_vec[g] = valid_vec[g] && (tag_vec[g] == lookup_addr);
  end

  always_comb begin
    hit     = |match_vec;
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match_vec[i]) hit_idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/assoc_cache_victim.sv
module assoc_cache_victim #(
  parameter int ENTRIES = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ENTRIES-1:0]   valid_vec,
  input  logic                 commit,
  output logic [((ENTRIES > 1) ? $clog2(ENTRIES) : 1)-1:0] victim_idx
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic             any_free;
  logic [IDX_W-1:0] free_idx;
  logic [IDX_W-1:0] ptr_q;

  // lowest-numbered empty line wins
  always_comb begin
    any_free = ~&valid_vec;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_vec[i]) free_idx = IDX_W'(i);
    end
    victim_idx = any_free ? free_idx : ptr_q;
  end

  // the rotating pointer moves only when a valid line is overwritten
  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else if (commit && !any_free) begin
      ptr_q <= (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

endmodule

// File: rtl/assoc_cache_store.sv
module assoc_cache_store #(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 16,
  parameter int ENTRIES = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic [((ENTRIES > 1) ? $clog2(ENTRIES) : 1)-1:0] wr_idx,
  input  logic [ADDR_W-1:0]              wr_addr,
  input  logic [DATA_W-1:0]              wr_data,
  input  logic [((ENTRIES > 1) ? $clog2(ENTRIES) : 1)-1:0] rd_idx,
  output logic [ENTRIES-1:0][ADDR_W-1:0] tag_vec,
  output logic [ENTRIES-1:0]             valid_vec,
  output logic [DATA_W-1:0]              rd_data
);
  logic [DATA_W-1:0] data_mem [ENTRIES];

  // tags and valid flags live in flops so every line can be compared at once
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_vec <= '0;
    end else if (wr_en) begin
      valid_vec[wr_idx] <= 1'b1;
      tag_vec[wr_idx]   <= wr_addr;
    end
  end

  // data words sit in a plain one-write one-read array
  always_ff @(posedge clk) begin
    if (wr_en) data_mem[wr_idx] <= wr_data;
  end

  assign rd_data = data_mem[rd_idx];

endmodule

// File: rtl/assoc_fifo_cache.sv
module assoc_fifo_cache #(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 16,
  parameter int ENTRIES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic [DATA_W-1:0] resp_data,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_data
);
  import assoc_cache_pkg::*;

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  cache_state_e                   state_q;
  logic                           req_ready_q;
  logic                           mem_req_q;
  logic [ADDR_W-1:0]              mem_addr_q;
  logic                           resp_valid_q;
  logic                           resp_hit_q;
  logic [DATA_W-1:0]              resp_data_q;

  logic [ENTRIES-1:0][ADDR_W-1:0] tag_vec;
  logic [ENTRIES-1:0]             valid_vec;
  logic                           lookup_hit;
  logic [IDX_W-1:0]               hit_idx;
  logic [IDX_W-1:0]               victim_idx;
  logic [DATA_W-1:0]              hit_data;
  logic                           accept;
  logic                           fill_done;

  assign accept    = req_valid && req_ready_q && (state_q == ST_LOOKUP);
  assign fill_done = (state_q == ST_FILL) && mem_ack;

  assoc_cache_match #(
    .ADDR_W (ADDR_W),
    .ENTRIES(ENTRIES)
  ) match_i (
    .lookup_addr(req_addr),
    .tag_vec    (tag_vec),
    .valid_vec  (valid_vec),
    .hit        (lookup_hit),
    .hit_idx    (hit_idx)
  );

  assoc_cache_victim #(
    .ENTRIES(ENTRIES)
  ) victim_i (
    .clk       (clk),
    .rst       (rst),
    .valid_vec (valid_vec),
    .commit    (fill_done),
    .victim_idx(victim_idx)
  );

  assoc_cache_store #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .ENTRIES(ENTRIES)
  ) store_i (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (fill_done),
    .wr_idx   (victim_idx),
    .wr_addr  (mem_addr_q),
    .wr_data  (mem_data),
    .rd_idx   (hit_idx),
    .tag_vec  (tag_vec),
    .valid_vec(valid_vec),
    .rd_data  (hit_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_LOOKUP;
      req_ready_q  <= 1'b1;
      mem_req_q    <= 1'b0;
      mem_addr_q   <= '0;
      resp_valid_q <= 1'b0;
      resp_hit_q   <= 1'b0;
      resp_data_q  <= '0;
    end else begin
      resp_valid_q <= 1'b0;
      resp_hit_q   <= 1'b0;
      case (state_q)
        ST_LOOKUP: begin
          if (accept) begin
            if (lookup_hit) begin
              resp_valid_q <= 1'b1;
              resp_hit_q   <= 1'b1;
              resp_data_q  <= hit_data;
            end else begin
              state_q     <= ST_FILL;
              req_ready_q <= 1'b0;
              mem_req_q   <= 1'b1;
              mem_addr_q  <= req_addr;
            end
          end
        end
        ST_FILL: begin
          if (mem_ack) begin
            state_q      <= ST_LOOKUP;
            req_ready_q  <= 1'b1;
            mem_req_q    <= 1'b0;
            resp_valid_q <= 1'b1;
            resp_data_q  <= mem_data;
          end
        end
        default: state_q <= ST_LOOKUP;
      endcase
    end
  end

  assign req_ready  = req_ready_q;
  assign mem_req    = mem_req_q;
  assign mem_addr   = mem_addr_q;
  assign resp_valid = resp_valid_q;
  assign resp_hit   = resp_hit_q;
  assign resp_data  = resp_data_q;

endmodule

// File: rtl/assoc_cache_checker.sv
module assoc_cache_checker #(
  parameter int ADDR_W  = 12,
  parameter int ENTRIES = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic               req_ready,
  input logic               resp_valid,
  input logic               resp_hit,
  input logic               mem_req,
  input logic [ADDR_W-1:0]  mem_addr,
  input logic               mem_ack,
  input logic [ENTRIES-1:0] valid_vec
);

  // R3: no new request can be taken while memory is being read
  assert_busy_blocks_R3: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !req_ready);

  // R3: the outstanding read holds its address until acknowledged
  assert_addr_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  // R4: an acknowledge completes the miss on the next cycle
  assert_ack_completes_R4: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ack) |=> (resp_valid && !resp_hit && !mem_req && req_ready));

  // R2: a hit response never overlaps a memory read
  assert_hit_no_mem_R2: assert property (@(posedge clk) disable iff (rst)
    resp_hit |-> (resp_valid && !mem_req));

  // R10: every response traces back to an accepted request or an acknowledge
  assert_resp_origin_R10: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> ($past(req_valid && req_ready) || $past(mem_req && mem_ack)));

  // R6: lines never become invalid once filled
  assert_valid_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    ($countones(valid_vec) >= $countones($past(valid_vec))));

endmodule

bind assoc_fifo_cache assoc_cache_checker #(
  .ADDR_W (ADDR_W),
  .ENTRIES(ENTRIES)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .resp_valid(resp_valid),
  .resp_hit  (resp_hit),
  .mem_req   (mem_req),
  .mem_addr  (mem_addr),
  .mem_ack   (mem_ack),
  .valid_vec (valid_vec)
);

// File: tb/assoc_fifo_cache_tb_top.sv
`timescale 1ns/1ps
module assoc_fifo_cache_tb_top;
  localparam int AW   = 12;
  localparam int DW   = 16;
  localparam int NENT = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          req_ready;
  logic          resp_valid;
  logic          resp_hit;
  logic [DW-1:0] resp_data;
  logic          mem_req;
  logic [AW-1:0] mem_addr;
  logic          mem_ack = 1'b0;
  logic [DW-1:0] mem_data = '0;

  always #2.5 clk = ~clk;

  assoc_fifo_cache #(.ADDR_W(AW), .DATA_W(DW), .ENTRIES(NENT)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .resp_valid(resp_valid), .resp_hit(resp_hit),
    .resp_data(resp_data), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_data(mem_data)
  );

  typedef struct {
    bit          hit;
    logic [15:0] data;
    logic [11:0] addr;
    int          due;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   ack_cyc = 0;
  int   checks = 0;
  int   errors = 0;

  // reference model of the cache contents
  logic [AW-1:0] m_addr [NENT];
  logic [DW-1:0] m_data [NENT];
  bit            m_val  [NENT];
  int            m_ptr = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] memword(input logic [11:0] a);
    int t;
    t = int'(a);
    return 16'((t * 40503 + 12345) ^ (t << 4));
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_lookup(input logic [11:0] a, output bit h, output logic [15:0] d);
    int v;
    h = 0;
    d = memword(a);
    for (int i = 0; i < NENT; i++) begin
      if (m_val[i] && m_addr[i] == a) begin
        h = 1;
        d = m_data[i];
      end
    end
    if (!h) begin
      v = -1;
      for (int i = NENT - 1; i >= 0; i--) if (!m_val[i]) v = i;
      if (v < 0) begin
        v = m_ptr;
        m_ptr = (m_ptr + 1) % NENT;
      end
      m_val[v]  = 1;
      m_addr[v] = a;
      m_data[v] = d;
    end
  endtask

  // driver: pushes the expected item, then presents the request
  task automatic access(input logic [11:0] a, input string tag,
                        input bit stray_en, input logic [11:0] stray_a);
    bit          h;
    logic [15:0] d;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    model_lookup(a, h, d);
    q.push_back('{h, d, a, cyc + 1, tag});
    req_valid = 1'b1;
    req_addr  = a;
    @(negedge clk);
    req_valid = 1'b0;
    if (stray_en) begin
      chk(req_ready == 1'b0, "R10", "ready low while filling", req_ready, 0);
      req_valid = 1'b1;
      req_addr  = stray_a;
      @(negedge clk);
      req_valid = 1'b0;
    end
    while (q.size() != 0) @(negedge clk);
  endtask

  // memory model with variable latency
  int lat_n = 0;
  always begin
    @(negedge clk);
    if (!rst && mem_req) begin
      if (q.size() == 0) begin
        chk(0, "R3", "memory read with no pending request", 1, 0);
      end else begin
        chk(!q[0].hit, "R2", "memory read on a hit", 1, 0);
        chk(mem_addr == q[0].addr, "R3", "mem_addr", mem_addr, q[0].addr);
        chk(req_ready == 1'b0, "R3", "req_ready during miss", req_ready, 0);
      end
      repeat (1 + (lat_n % 3)) @(negedge clk);
      lat_n++;
      chk(mem_req == 1'b1, "R3", "mem_req held until ack", mem_req, 1);
      mem_data = memword(mem_addr);
      mem_ack  = 1'b1;
      ack_cyc  = cyc;
      @(negedge clk);
      mem_ack  = 1'b0;
      chk(mem_req == 1'b0, "R4", "mem_req dropped after ack", mem_req, 0);
      chk(req_ready == 1'b1, "R4", "req_ready back after ack", req_ready, 1);
    end
  end

  // monitor: pops and compares each response
  always @(negedge clk) begin
    if (!rst && resp_valid) begin
      if (q.size() == 0) begin
        chk(0, "R10", "response with nothing pending", 1, 0);
      end else begin
        exp_t e;
        int   due;
        e = q.pop_front();
        due = e.hit ? e.due : ack_cyc + 1;
        chk(resp_hit == e.hit, e.tag, "resp_hit", resp_hit, e.hit);
        chk(resp_data == e.data, e.tag, "resp_data", resp_data, e.data);
        chk(cyc == due, e.hit ? "R2" : "R4", "response cycle", cyc, due);
      end
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R4 actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [11:0] pool [6];
    int          lf;
    for (int i = 0; i < NENT; i++) m_val[i] = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);
    chk(resp_valid == 1'b0, "R1", "resp_valid after reset", resp_valid, 0);
    chk(mem_req == 1'b0, "R1", "mem_req after reset", mem_req, 0);

    // R1/R6: fill empty lines; R9: 045 and 445 differ only in the upper bits
    access(12'h045, "R1", 0, '0);
    access(12'h445, "R9", 0, '0);
    access(12'h100, "R6", 0, '0);
    access(12'h7FF, "R6", 0, '0);
    // R5/R2: all four now hit
    access(12'h045, "R5", 0, '0);
    access(12'h445, "R9", 0, '0);
    access(12'h100, "R2", 0, '0);
    access(12'h7FF, "R2", 0, '0);
    // R7: full cache, oldest (045) leaves
    access(12'hA00, "R7", 0, '0);
    // R8: hits in between do not move the pointer
    access(12'h445, "R8", 0, '0);
    access(12'h100, "R8", 0, '0);
    access(12'h7FF, "R8", 0, '0);
    access(12'hA00, "R8", 0, '0);
    access(12'h045, "R7", 0, '0);
    access(12'h100, "R8", 0, '0);
    access(12'h445, "R7", 0, '0);
    // R10: stray requests during a fill are dropped
    access(12'h3C3, "R10", 1, 12'h7FF);
    access(12'h2B2, "R10", 1, 12'h111);
    access(12'h111, "R10", 0, '0);
    access(12'h7FF, "R10", 0, '0);

    // R7: longer mixed stream against the model
    pool[0] = 12'h045; pool[1] = 12'h445; pool[2] = 12'h100;
    pool[3] = 12'hC45; pool[4] = 12'h001; pool[5] = 12'h7FF;
    lf = 7;
    for (int n = 0; n < 60; n++) begin
      lf = (lf * 13 + 5) % 97;
      access(pool[lf % 6], "R7", 0, '0);
    end

    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R4", "all responses delivered", q.size(), 0);
    finish_run();
  end

endmodule